// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Status Flags

This block recovers 8-bit words from an asynchronous serial line that it samples at sixteen times the bit rate. A word arrives as one low start bit, eight data bits with the least significant bit first, and one high stop bit. Every bit is decided by a two-out-of-three vote over three samples taken around its centre. A disagreement among those samples marks the word as noisy. A low stop bit marks it as a framing failure.

Each completed word lands in a one-word holding register and sets a "word ready" flag. If a word completes while the previous one is still unread, the new word is dropped and an overrun flag is raised in its place. A separate detector flags a quiet line once ten bit times of continuous high level follow any low activity. Software reads one status byte and the holding register through a single read port. Flags are cleared by a two-step sequence: a status read followed by a data read. The data read clears only those flags that the status read saw. Two interrupt outputs are the flags gated by their enables.

Top module: `uart_rx_flags`

## Requirements
- R1: A frame of one low start bit, eight data bits (LSB first) and a stop bit loads the holding register and sets status bit 0 (word ready), unless an overrun occurs.
- R2: Each bit is sampled on oversample ticks 7, 8 and 9 of its 16-tick period and takes the majority value. Any disagreement among the three samples of any bit in the frame sets status bit 3 (noise) with the word.
- R3: A start bit whose majority vote is high is rejected. The receiver returns to hunting, and no word, flag or noise is recorded.
- R4: A stop bit whose majority vote is low sets status bit 4 (framing error) with the word.
- R5: A word that completes while status bit 0 is set and is not being cleared in that cycle sets status bit 2 (overrun). The new word is discarded, and the holding register and noise flag are unchanged.
- R6: A word that causes both an overrun and a framing error sets only the overrun flag. Status bit 4 does not change.
- R7: A status read (rd_sel=0) records the flags set at that moment. The next data read (rd_sel=1) clears exactly those flags. A data read with no status read before it clears nothing. A flag that sets after the status read survives the data read.
- R8: Status bit 1 (idle) sets once when the synchronised line has been high for 160 consecutive ticks (10 bit times), counted after a low level. It does not set again until the line has gone low again, and it does not set after reset before any low level.
- R9: irq_idle equals idle AND ilie, and irq_rx equals (word ready OR overrun) AND rie, with no extra delay.
- R10: If a data read that clears word ready falls in the same cycle as a word completing, the read returns the old word. The new word is accepted without overrun, and word ready stays set.
- R11: Synchronous reset clears all five flags, the holding register and rd_data.
- R12: rd_data presents the selected register on the clock edge that samples rd_en. Status uses bits 4..0 as listed above, and bits 7..5 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversample enable, 16 per bit time |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rd_en | input | 1 | Read strobe, one cycle |
| rd_sel | input | 1 | 0 = status byte, 1 = holding register |
| ilie | input | 1 | Idle interrupt enable |
| rie | input | 1 | Receive/overrun interrupt enable |
| rd_data | output | 8 | Registered read data |
| irq_idle | output | 1 | Idle interrupt request |
| irq_rx | output | 1 | Word-ready or overrun interrupt request |

## Verification
Two functions can coincide in one cycle: a word completing, and the data read that empties the holding register. The bench places the read strobe so that it is sampled on exactly the edge where the finished word reaches the flag logic, which is 157 cycles after the start bit first appears on rxd. It then judges that the read returned the previous word, that the new word was accepted, and that no overrun appeared. A second case completes a word between the status read and the data read, and checks that the overrun raised in between survives the clear.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_START, ST_DATA, ST_STOP} rx_state_e;

  // packed order gives bit positions 4..0 of the status byte
  typedef struct packed {
    logic fe;
    logic nf;
    logic ovr;
    logic idl;
    logic rdf;
  } rx_flags_t;

  localparam int FLAG_W = 5;
endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd,
  output logic              rxd_s,
  output logic              done,
  output logic [DATA_W-1:0] word,
  output logic              noise,
  output logic              ferr
);
  import uart_rx_pkg::*;

  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] SMP_A = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] SMP_B = CNT_W'(OVS / 2);
  localparam logic [CNT_W-1:0] SMP_C = CNT_W'(OVS / 2 + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic              meta;
  rx_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bidx;
  logic [1:0]        smp;
  logic [DATA_W-1:0] sh;
  logic              nacc;
  logic              vote;
  logic              split;

  always_comb begin
    vote  = (smp[0] & smp[1]) | (smp[0] & rxd_s) | (smp[1] & rxd_s);
    split = !((smp[0] == smp[1]) && (smp[1] == rxd_s));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      meta  <= 1'b1;
      rxd_s <= 1'b1;
      st    <= ST_HUNT;
      cnt   <= '0;
      bidx  <= '0;
      smp   <= '0;
      sh    <= '0;
      nacc  <= 1'b0;
      done  <= 1'b0;
      word  <= '0;
      noise <= 1'b0;
      ferr  <= 1'b0;
    end else begin
      meta  <= rxd;
      rxd_s <= meta;
      done  <= 1'b0;
      if (tick) begin
        if (st == ST_HUNT) begin
          if (!rxd_s) begin
            st   <= ST_START;
            cnt  <= CNT_W'(1);
            bidx <= '0;
            nacc <= 1'b0;
          end
        end else begin
          cnt <= (cnt == CNT_TOP) ? '0 : cnt + 1'b1;
          if (cnt == SMP_A) smp[0] <= rxd_s;
          if (cnt == SMP_B) smp[1] <= rxd_s;
          if (cnt == SMP_C) begin
            case (st)
              ST_START: begin
                if (vote) st <= ST_HUNT;
                else begin
                  st   <= ST_DATA;
                  nacc <= split;
                end
              end
              ST_DATA: begin
                sh   <= {vote, sh[DATA_W-1:1]};
                nacc <= nacc | split;
                bidx <= bidx + 1'b1;
                if (bidx == LAST_BIT) st <= ST_STOP;
              end
              ST_STOP: begin
                st    <= ST_HUNT;
                done  <= 1'b1;
                word  <= sh;
                noise <= nacc | split;
                ferr  <= !vote;
              end
              default: st <= ST_HUNT;
            endcase
          end
        end
      end
    end
  end

  // R1: a word is only delivered out of the stop-bit state
  a_r1_done_after_stop: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(st == ST_STOP));

  // R3: a rejected start never yields a word on the next cycle
  a_r3_false_start_quiet: assert property (@(posedge clk) disable iff (rst)
    ($past(st == ST_START) && st == ST_HUNT) |-> !done);
endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle #(
  parameter int OVS       = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rxd_s,
  output logic pulse
);
  localparam int LIMIT = OVS * IDLE_BITS;
  localparam int CW    = $clog2(LIMIT);
  localparam logic [CW-1:0] CNT_LAST = CW'(LIMIT - 1);

  logic          armed;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (tick) begin
        if (!rxd_s) begin
          armed <= 1'b1;
          cnt   <= '0;
        end else if (armed) begin
          if (cnt == CNT_LAST) begin
            pulse <= 1'b1;
            armed <= 1'b0;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  // R8: one detection per quiet period
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W-1:0] word,
  input  logic              noise,
  input  logic              ferr,
  input  logic              idle_pulse,
  input  logic              rd_en,
  input  logic              rd_sel,
  output uart_rx_pkg::rx_flags_t flg,
  output logic [DATA_W-1:0] rd_data
);
  import uart_rx_pkg::*;

  rx_flags_t         arm;
  rx_flags_t         clr;
  rx_flags_t         nxt;
  logic [DATA_W-1:0] dreg;
  logic              st_rd;
  logic              dt_rd;
  logic              room;

  always_comb begin
    st_rd = rd_en & !rd_sel;
    dt_rd = rd_en & rd_sel;
    clr   = dt_rd ? arm : '0;
    room  = !flg.rdf || clr.rdf;
    nxt   = flg & ~clr;
    if (idle_pulse) nxt.idl = 1'b1;
    if (done) begin
      if (room) begin
        nxt.rdf = 1'b1;
        nxt.nf  = nxt.nf | noise;
        nxt.fe  = nxt.fe | ferr;
      end else begin
        nxt.ovr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flg     <= '0;
      arm     <= '0;
      dreg    <= '0;
      rd_data <= '0;
    end else begin
      flg <= nxt;
      if (st_rd)      arm <= flg;
      else if (dt_rd) arm <= '0;
      if (done && room) dreg <= word;
      if (rd_en) rd_data <= rd_sel ? dreg : DATA_W'(flg);
    end
  end

  // R5: a dropped word leaves the holding register alone
  a_r5_keep_word: assert property (@(posedge clk) disable iff (rst)
    (done && flg.rdf && !dt_rd) |=> dreg == $past(dreg));

  // R6: overrun masks the framing flag
  a_r6_fe_masked: assert property (@(posedge clk) disable iff (rst)
    (done && flg.rdf && !dt_rd) |=> flg.fe == $past(flg.fe));

  // R7: overrun only drops through a data read
  a_r7_clear_by_read: assert property (@(posedge clk) disable iff (rst)
    $fell(flg.ovr) |-> $past(dt_rd));

  // R8: idle flag only rises after the detector fires
  a_r8_idle_source: assert property (@(posedge clk) disable iff (rst)
    $rose(flg.idl) |-> $past(idle_pulse));
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags #(
  parameter int DATA_W    = 8,
  parameter int OVS       = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic              ilie,
  input  logic              rie,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_idle,
  output logic              irq_rx
);
  import uart_rx_pkg::*;

  logic              rxd_s;
  logic              done;
  logic [DATA_W-1:0] word;
  logic              noise;
  logic              ferr;
  logic              idle_pulse;
  rx_flags_t         flg;

  uart_rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk(clk), .rst(rst), .tick(tick16), .rxd(rxd), .rxd_s(rxd_s),
    .done(done), .word(word), .noise(noise), .ferr(ferr)
  );

  uart_rx_idle #(.OVS(OVS), .IDLE_BITS(IDLE_BITS)) u_idle (
    .clk(clk), .rst(rst), .tick(tick16), .rxd_s(rxd_s), .pulse(idle_pulse)
  );

  uart_rx_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst(rst), .done(done), .word(word), .noise(noise),
    .ferr(ferr), .idle_pulse(idle_pulse), .rd_en(rd_en), .rd_sel(rd_sel),
    .flg(flg), .rd_data(rd_data)
  );

  always_comb begin
    irq_idle = flg.idl & ilie;
    irq_rx   = (flg.rdf | flg.ovr) & rie;
  end

  // R9: receive request is never raised while its enable is low
  a_r9_rx_gated: assert property (@(posedge clk) disable iff (rst)
    !rie |-> !irq_rx);
endmodule

// File: tb/uart_rx_flags_test.sv
module uart_rx_flags_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b1;
  logic       rxd = 1'b1;
  logic       rd_en = 1'b0;
  logic       rd_sel = 1'b0;
  logic       ilie = 1'b0;
  logic       rie = 1'b0;
  logic [7:0] rd_data;
  logic       irq_idle;
  logic       irq_rx;
  int         n_chk = 0;
  int         n_bad = 0;
  logic [7:0] v;

  // {data, stop level, glitched frame bit (15 = none), expected status}
  localparam logic [20:0] VEC [7] = '{
    {8'h55, 1'b1, 4'd15, 8'h01},
    {8'hA3, 1'b1, 4'd3,  8'h09},
    {8'h0F, 1'b0, 4'd15, 8'h11},
    {8'hFE, 1'b1, 4'd0,  8'h09},
    {8'h80, 1'b1, 4'd9,  8'h09},
    {8'h3C, 1'b0, 4'd5,  8'h19},
    {8'hC6, 1'b1, 4'd8,  8'h09}
  };

  always #10 clk = ~clk;

  uart_rx_flags uut (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .rd_en(rd_en),
    .rd_sel(rd_sel), .ilie(ilie), .rie(rie), .rd_data(rd_data),
    .irq_idle(irq_idle), .irq_rx(irq_rx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic stopv, input int gbit, input int rd_at);
    logic [9:0] fr;
    fr = {stopv, d, 1'b0};
    @(posedge clk); #1;
    for (int k = 0; k < 10; k++) begin
      for (int j = 0; j < 16; j++) begin
        rxd    = (k == gbit && j == 8) ? ~fr[k] : fr[k];
        rd_en  = (k * 16 + j == rd_at);
        rd_sel = 1'b1;
        @(posedge clk); #1;
      end
    end
    rxd   = 1'b1;
    rd_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] val);
    @(posedge clk); #1;
    rd_en  = 1'b1;
    rd_sel = sel;
    @(posedge clk); #1;
    rd_en = 1'b0;
    val   = rd_data;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    summary();
  end

  initial begin
    ilie = 1'b1;
    rie  = 1'b1;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    chk("R11 rd_data after reset", rd_data, 0);
    chk("R11 irq_rx after reset", irq_rx, 0);
    chk("R11 irq_idle after reset", irq_idle, 0);
    rd(1'b0, v); chk("R11 status after reset", v, 8'h00);
    repeat (300) @(posedge clk);
    rd(1'b0, v); chk("R8 no idle before any low level", v, 8'h00);

    // table walk: R1 R2 R4 R7 R12
    for (int i = 0; i < 7; i++) begin
      send(VEC[i][20:13], VEC[i][12], int'(VEC[i][11:8]), -1);
      rd(1'b0, v); chk("R2/R4/R12 status after frame", v & 8'hFD, VEC[i][7:0]);
      rd(1'b1, v); chk("R1 received word", v, VEC[i][20:13]);
      rd(1'b0, v); chk("R7 flags cleared by sequence", v & 8'hFD, 8'h00);
    end
    rd(1'b0, v); rd(1'b1, v);

    // R7: data read alone clears nothing
    send(8'h5A, 1'b1, 15, -1);
    rd(1'b1, v); chk("R1 word 5A", v, 8'h5A);
    rd(1'b0, v); chk("R7 data read alone keeps ready", v, 8'h01);
    rd(1'b1, v);
    rd(1'b0, v); chk("R7 cleared after full sequence", v, 8'h00);

    // R5 R6 R9: overrun with framing error in the dropped word
    rie = 1'b0;
    send(8'h11, 1'b1, 15, -1);
    #1 chk("R9 irq_rx gated off", irq_rx, 0);
    rie = 1'b1;
    #1 chk("R9 irq_rx on ready", irq_rx, 1);
    send(8'h22, 1'b0, 15, -1);
    rd(1'b0, v); chk("R5/R6 overrun without framing", v, 8'h05);
    rd(1'b1, v); chk("R5 old word kept", v, 8'h11);
    rd(1'b0, v); chk("R7 overrun cleared", v, 8'h00);
    #1 chk("R9 irq_rx drops after clear", irq_rx, 0);

    // R7: flag set after status read survives data read
    send(8'h44, 1'b1, 15, -1);
    rd(1'b0, v); chk("R7 arm ready only", v, 8'h01);
    send(8'h66, 1'b1, 15, -1);
    rd(1'b1, v); chk("R5 word 44 kept on late overrun", v, 8'h44);
    rd(1'b0, v); chk("R7 late overrun survives", v, 8'h04);
    #1 chk("R9 irq_rx held by overrun", irq_rx, 1);
    rd(1'b1, v);
    rd(1'b0, v); chk("R7 late overrun cleared next round", v, 8'h00);

    // R10: clearing data read coincides with word completion
    send(8'h77, 1'b1, 15, -1);
    rd(1'b0, v); chk("R10 arm ready", v, 8'h01);
    send(8'h99, 1'b1, 15, 156);
    chk("R10 coincident read returns old word", rd_data, 8'h77);
    rd(1'b0, v); chk("R10 no overrun, ready kept", v, 8'h01);
    rd(1'b1, v); chk("R10 new word accepted", v, 8'h99);
    rd(1'b0, v); rd(1'b1, v);
    rd(1'b0, v); chk("R7 clean before idle test", v, 8'h00);

    // R3 R8 R9: short low blip is a false start, then a quiet line
    @(posedge clk); #1 rxd = 1'b0;
    repeat (3) @(posedge clk);
    #1 rxd = 1'b1;
    repeat (157) @(posedge clk);
    #1 chk("R8 idle not yet at 154 high ticks", irq_idle, 0);
    repeat (10) @(posedge clk);
    #1 chk("R8 idle after 10 bit times", irq_idle, 1);
    ilie = 1'b0;
    #1 chk("R9 irq_idle gated off", irq_idle, 0);
    rd(1'b0, v); chk("R3/R8 idle set, no word from false start", v, 8'h02);
    rd(1'b1, v);
    repeat (400) @(posedge clk);
    rd(1'b0, v); chk("R8 idle not re-raised without low", v, 8'h00);

    // R11: reset clears pending flags
    send(8'h12, 1'b0, 2, -1);
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    rd(1'b0, v); chk("R11 flags cleared by reset", v, 8'h00);
    rd(1'b1, v); chk("R11 holding register cleared", v, 8'h00);

    summary();
  end
endmodule